// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for one load or store and the new value of its base register. It takes a base value and an offset, which is either a zero-extended immediate or a full-width register value. Four independent control inputs set the behaviour. The first chooses pre-indexing or post-indexing. The second chooses whether the offset is added or subtracted. The third chooses a byte or a word transfer. The fourth asks for the base register to be updated.

From these inputs the block produces four things: the bus address, the byte-lane enables for the data bus, the size select, and the base update with its enable. All of these are registered, and a one-cycle valid strobe follows each accepted request. A post-indexed access always updates the base, whatever the update request says.

The block also turns returned bus data into a register value. For a byte access it selects the addressed lane and zero-extends it. For a word access it passes the data through. Lane selection uses the registered access, so the read data may arrive any time before the next request.

Top module: `lsu_agu`

## Requirements
- R1: With pre_index=1, bus_addr is base_addr combined with the offset (before word alignment).
- R2: With pre_index=0, bus_addr is the unmodified base_addr (before word alignment).
- R3: With add_off=1 the offset is added to the base, and with add_off=0 it is subtracted. Both results wrap modulo 2^ADDR_W.
- R4: With off_is_imm=1 the offset is imm_off, zero-extended, and reg_off has no effect. With off_is_imm=0 the offset is reg_off.
- R5: wb_value is base_addr combined with the offset. wb_en is 1 when wb_req=1 or pre_index=0, and 0 otherwise.
- R6: With byte_xfer=0 (word), size_byte=0, bus_addr bits 1:0 are forced to 0, and lane_en is all ones.
- R7: With byte_xfer=1, size_byte=1 and bus_addr keeps its low bits. Exactly one bit of lane_en is set, with index equal to address bits 1:0. Lane k carries data bits 8k+7:8k.
- R8: load_data is rd_data for a word access. For a byte access it is the byte in the lane named by the registered address bits 1:0, zero-extended.
- R9: out_valid is 1 in exactly the cycle after a clock edge at which req_valid=1. Between requests the registered outputs hold their values.
- R10: After reset, out_valid, wb_en and lane_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request accepted at this edge |
| base_addr | input | ADDR_W | Base register value |
| imm_off | input | IMM_W | Immediate offset |
| reg_off | input | ADDR_W | Register offset value |
| off_is_imm | input | 1 | 1: immediate offset, 0: register offset |
| pre_index | input | 1 | 1: apply offset before transfer, 0: after |
| add_off | input | 1 | 1: add offset, 0: subtract |
| byte_xfer | input | 1 | 1: byte transfer, 0: word |
| wb_req | input | 1 | Request base update |
| rd_data | input | DATA_W | Data returned from the bus |
| out_valid | output | 1 | Registered results valid |
| bus_addr | output | ADDR_W | Transfer address |
| wb_value | output | ADDR_W | New base value |
| wb_en | output | 1 | Base update enable |
| size_byte | output | 1 | 1: byte size, 0: word |
| lane_en | output | DATA_W/8 | Byte-lane enables |
| load_data | output | DATA_W | Aligned load result |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit data bus (four lanes) and a 12-bit immediate. At that width the largest immediate, 0xFFF, can be applied. Additions and subtractions can be pushed across the 2^32 boundary in both directions. Every one of the four lanes can be reached by a byte access, and the same data word shows each lane's byte being extracted.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
   // Byte width of one bus lane.
   localparam int unsigned LANE_BITS = 8;

   // Control bits of one access, as captured with the request.
   typedef struct packed {
      logic pre;
      logic up;
      logic byte_sz;
      logic wback;
   } agu_mode_t;
endpackage

// File: rtl/lsu_offset_unit.sv
module lsu_offset_unit #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IMM_W  = 12
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic              use_imm,
   input  lsu_agu_pkg::agu_mode_t mode,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [ADDR_W-1:0] next_base
);
   localparam int unsigned PAD_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] off;

   // Zero-extend the immediate to the address width.
   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm};
      end else begin : g_nopad
         assign imm_ext = imm[ADDR_W-1:0];
      end
   endgenerate

   assign off       = use_imm ? imm_ext : reg_off;
   assign next_base = mode.up ? (base + off) : (base - off);
   assign xfer_addr = mode.pre ? next_base : base;
endmodule

// File: rtl/lsu_lane_gen.sv
module lsu_lane_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LANES  = 4
) (
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic              byte_sz,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LANES-1:0]  lane_en
);
   localparam int unsigned LSB_W = $clog2(LANES);

   // A word access is aligned; a byte access keeps its low bits.
   assign bus_addr = byte_sz ? xfer_addr
                             : {xfer_addr[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lane_en[k] = byte_sz ? (xfer_addr[LSB_W-1:0] == LSB_W'(k)) : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]                 rdata,
   input  logic [$clog2(DATA_W/8)-1:0]       lane_idx,
   input  logic                              byte_sz,
   output logic [DATA_W-1:0]                 load_data
);
   localparam int unsigned LANES = DATA_W / lsu_agu_pkg::LANE_BITS;

   logic [7:0] lane_byte [LANES];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_split
         assign lane_byte[k] = rdata[8*k +: 8];
      end
   endgenerate

   assign load_data = byte_sz ? {{(DATA_W-8){1'b0}}, lane_byte[lane_idx]} : rdata;
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          base_addr,
   input  logic [IMM_W-1:0]           imm_off,
   input  logic [ADDR_W-1:0]          reg_off,
   input  logic                       off_is_imm,
   input  logic                       pre_index,
   input  logic                       add_off,
   input  logic                       byte_xfer,
   input  logic                       wb_req,
   input  logic [DATA_W-1:0]          rd_data,
   output logic                       out_valid,
   output logic [ADDR_W-1:0]          bus_addr,
   output logic [ADDR_W-1:0]          wb_value,
   output logic                       wb_en,
   output logic                       size_byte,
   output logic [DATA_W/8-1:0]        lane_en,
   output logic [DATA_W-1:0]          load_data
);
   import lsu_agu_pkg::*;

   localparam int unsigned LANES = DATA_W / LANE_BITS;
   localparam int unsigned LSB_W = $clog2(LANES);

   // Elaboration-time parameter checks.
   generate
      if ((DATA_W % LANE_BITS) != 0 || LANES < 2 || (1 << LSB_W) != LANES) begin : g_bad_data
         $error("lsu_agu: DATA_W must be a power-of-two multiple of 8, at least 16");
      end
      if (IMM_W == 0 || IMM_W > ADDR_W) begin : g_bad_imm
         $error("lsu_agu: IMM_W must be between 1 and ADDR_W");
      end
      if (ADDR_W <= LSB_W) begin : g_bad_addr
         $error("lsu_agu: ADDR_W too small for the lane count");
      end
   endgenerate

   agu_mode_t         mode;
   logic [ADDR_W-1:0] xfer_addr;
   logic [ADDR_W-1:0] next_base;
   logic [ADDR_W-1:0] bus_addr_d;
   logic [LANES-1:0]  lane_en_d;
   logic [LSB_W-1:0]  lane_idx_q;

   assign mode = '{pre: pre_index, up: add_off, byte_sz: byte_xfer, wback: wb_req};

   lsu_offset_unit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_offset (
      .base      (base_addr),
      .imm       (imm_off),
      .reg_off   (reg_off),
      .use_imm   (off_is_imm),
      .mode      (mode),
      .xfer_addr (xfer_addr),
      .next_base (next_base)
   );

   lsu_lane_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lanes (
      .xfer_addr (xfer_addr),
      .byte_sz   (mode.byte_sz),
      .bus_addr  (bus_addr_d),
      .lane_en   (lane_en_d)
   );

   // Registered access results; held between requests.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         bus_addr   <= '0;
         wb_value   <= '0;
         wb_en      <= 1'b0;
         size_byte  <= 1'b0;
         lane_en    <= '0;
         lane_idx_q <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            bus_addr   <= bus_addr_d;
            wb_value   <= next_base;
            wb_en      <= mode.wback | ~mode.pre;
            size_byte  <= mode.byte_sz;
            lane_en    <= lane_en_d;
            lane_idx_q <= xfer_addr[LSB_W-1:0];
         end
      end
   end

   lsu_load_align #(.DATA_W(DATA_W)) u_align (
      .rdata     (rd_data),
      .lane_idx  (lane_idx_q),
      .byte_sz   (size_byte),
      .load_data (load_data)
   );

   // R9: strobe follows an accepted request by one cycle
   a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(req_valid));

   // R5: a post-indexed access always updates the base
   a_r5_post_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(pre_index)) |-> wb_en);

   // R6: word accesses are aligned and use every lane
   a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !size_byte) |-> (bus_addr[LSB_W-1:0] == '0 && &lane_en));

   // R7: byte accesses enable a single lane
   a_r7_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && size_byte) |-> ($countones(lane_en) == 1 && lane_en[bus_addr[LSB_W-1:0]]));

   // R8: byte loads are zero-extended
   a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && size_byte) |-> (load_data[DATA_W-1:8] == '0));

   // R2: a post-indexed word transfer uses the aligned base
   a_r2_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(pre_index) && !size_byte) |->
         (bus_addr[ADDR_W-1:LSB_W] == $past(base_addr[ADDR_W-1:LSB_W])));
endmodule

// File: tb/lsu_agu_tb_top.sv
module lsu_agu_tb_top;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned IMM_W  = 12;
   localparam int unsigned LANES  = DATA_W / 8;

   typedef struct {
      logic [ADDR_W-1:0] addr;
      logic [ADDR_W-1:0] wbv;
      logic              wbe;
      logic              szb;
      logic [LANES-1:0]  lanes;
      logic [DATA_W-1:0] load;
      string             tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] base_addr = '0;
   logic [IMM_W-1:0]  imm_off = '0;
   logic [ADDR_W-1:0] reg_off = '0;
   logic off_is_imm = 1'b0, pre_index = 1'b0, add_off = 1'b0, byte_xfer = 1'b0, wb_req = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic out_valid, wb_en, size_byte;
   logic [ADDR_W-1:0] bus_addr, wb_value;
   logic [LANES-1:0]  lane_en;
   logic [DATA_W-1:0] load_data;

   int n_checks = 0;
   int n_err = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   lsu_agu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_addr(base_addr),
      .imm_off(imm_off), .reg_off(reg_off), .off_is_imm(off_is_imm),
      .pre_index(pre_index), .add_off(add_off), .byte_xfer(byte_xfer),
      .wb_req(wb_req), .rd_data(rd_data), .out_valid(out_valid),
      .bus_addr(bus_addr), .wb_value(wb_value), .wb_en(wb_en),
      .size_byte(size_byte), .lane_en(lane_en), .load_data(load_data)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: applies one request at a falling edge and queues its expected result.
   task automatic drive(input logic [ADDR_W-1:0] b, input logic [IMM_W-1:0] im,
                        input logic [ADDR_W-1:0] ro, input bit use_imm, input bit p,
                        input bit u, input bit by, input bit w,
                        input logic [DATA_W-1:0] rd, input string tag);
      exp_t e;
      logic [ADDR_W-1:0] off, modv, xa;
      off  = use_imm ? ADDR_W'(im) : ro;                 // R4
      modv = u ? b + off : b - off;                      // R3
      xa   = p ? modv : b;                               // R1, R2
      e.addr  = by ? xa : {xa[ADDR_W-1:2], 2'b00};       // R6
      e.wbv   = modv;                                    // R5
      e.wbe   = w | ~p;
      e.szb   = by;
      e.lanes = by ? LANES'(1) << xa[1:0] : '1;          // R7
      e.load  = by ? DATA_W'(rd[8*xa[1:0] +: 8]) : rd;   // R8
      e.tag   = tag;
      @(negedge clk);
      base_addr = b; imm_off = im; reg_off = ro; off_is_imm = use_imm;
      pre_index = p; add_off = u; byte_xfer = by; wb_req = w; rd_data = rd;
      req_valid = 1'b1;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // Monitor: samples 1 ns after each rising edge and compares with the queue.
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected strobe", 64'(out_valid), 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(bus_addr == e.addr, {e.tag, " bus_addr"}, 64'(bus_addr), 64'(e.addr));
            check(wb_value == e.wbv, {e.tag, " wb_value (R5)"}, 64'(wb_value), 64'(e.wbv));
            check(wb_en == e.wbe, {e.tag, " wb_en (R5)"}, 64'(wb_en), 64'(e.wbe));
            check(size_byte == e.szb, {e.tag, " size_byte"}, 64'(size_byte), 64'(e.szb));
            check(lane_en == e.lanes, {e.tag, " lane_en"}, 64'(lane_en), 64'(e.lanes));
            check(load_data == e.load, {e.tag, " load_data (R8)"}, 64'(load_data), 64'(e.load));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [ADDR_W-1:0] held;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
      check(wb_en == 1'b0, "R10 wb_en", 64'(wb_en), 64'd0);
      check(lane_en == '0, "R10 lane_en", 64'(lane_en), 64'd0);
      rst_n = 1'b1;
      idle(2);

      // R1 R3 R4: pre-index, add, immediate, no write-back
      drive(32'h0000_1000, 12'h010, 32'hDEAD_BEEF, 1, 1, 1, 0, 0, 32'h1122_3344, "R1 pre add imm");
      idle(1);
      // R1 R3 R5: pre-index, subtract, register offset, write-back
      drive(32'h0000_2000, 12'h000, 32'h0000_0020, 0, 1, 0, 0, 1, 32'h5566_7788, "R3 pre sub reg");
      idle(1);
      // R2 R5: post-index writes back even with wb_req=0
      drive(32'h0000_3000, 12'h044, 32'h0, 1, 0, 1, 0, 0, 32'h99AA_BBCC, "R2 post add");
      idle(1);
      drive(32'h0000_3000, 12'h044, 32'h0, 1, 0, 0, 0, 1, 32'h99AA_BBCC, "R2 post sub");
      idle(1);
      // R7 R8: every lane, same data word
      for (int k = 0; k < 4; k++) begin
         drive(32'h0000_4000 + 32'(k), 12'h0, 32'h0, 1, 1, 1, 1, 0, 32'hA1B2_C3D4, "R7 byte lane");
         idle(1);
      end
      // R7: byte via pre-index offset landing on lane 3
      drive(32'h0000_5000, 12'h007, 32'h0, 1, 1, 1, 1, 0, 32'h0F1E_2D3C, "R7 byte pre");
      idle(1);
      // R6: unaligned word address forced aligned, data passed through
      drive(32'h0000_1003, 12'h000, 32'h0, 1, 1, 1, 0, 0, 32'hCAFE_F00D, "R6 word align");
      idle(1);
      // R3: wrap in both directions
      drive(32'hFFFF_FFF0, 12'h000, 32'h0000_0020, 0, 1, 1, 0, 1, 32'h0, "R3 wrap up");
      idle(1);
      drive(32'h0000_0008, 12'h010, 32'h0, 1, 1, 0, 0, 1, 32'h0, "R3 wrap down");
      idle(1);
      // R4: largest immediate, reg_off holds noise
      drive(32'h0001_0000, 12'hFFF, 32'h1234_5678, 1, 1, 1, 1, 0, 32'h0102_0304, "R4 max imm");
      idle(1);
      // R9: back-to-back requests
      drive(32'h0000_6000, 12'h004, 32'h0, 1, 1, 1, 0, 0, 32'h0, "R9 b2b first");
      drive(32'h0000_6100, 12'h008, 32'h0, 1, 0, 0, 1, 1, 32'h0, "R9 b2b second");
      idle(3);
      // R9: outputs hold while idle
      held = bus_addr;
      check(out_valid == 1'b0, "R9 strobe low when idle", 64'(out_valid), 64'd0);
      idle(3);
      check(bus_addr == held, "R9 bus_addr held", 64'(bus_addr), 64'(held));
      check(sb.size() == 0, "R9 all results seen", 64'(sb.size()), 64'd0);
      finish_run();
   end
endmodule